// File: doc/BRIEF.md
# Multi-Word Serial Output Formatter

This block takes one sample made of up to three parallel result words, for example I, Q and magnitude. It sends the sample out on a single serial data line, one bit per clock, with a one-bit sync strobe beside it. Each accepted sample begins a frame. The frame contains the selected number of words, sent most significant bit first. Each word may be cut to fewer bits than its full width; the bits sent are then the upper ones.

A configuration input is captured together with each sample. It sets the following:
- the word count;
- whether the last two word slots swap places;
- the bits sent per word;
- whether the sync strobe comes just before the first bit or just after the last bit;
- the active level of the sync strobe.

Two instances that share the configuration signals apply the same word order on two serial lines.

The sample input is a valid/ready stream that never applies back-pressure. `in_ready` is always high, so every cycle with `in_valid` high hands over a sample. A sample that arrives while a frame is still being sent replaces that frame at once. If samples keep arriving faster than a frame can finish in late-sync mode, no sync strobe is ever produced.

Top module: `ser_out_fmt`

## Requirements
- R1: `in_ready` is high in every cycle, including during reset. A cycle with `in_valid` high always accepts the sample, and the frame timing of that sample counts from the cycle after acceptance.
- R2: An accepted sample's words are sent MSB first, with `cfg_len_m1`+1 bits per word taken from bit 15 downward. The word count is `cfg_nwords` (1 to 3), and a count of 0 acts as 1.
- R3: Word slot k is bits 16k+15:16k of `in_words`. With `cfg_swap`=0 the slots are sent in the order 0, 1, 2. With `cfg_swap`=1 slots 1 and 2 exchange places, so the order is 0, 2, 1.
- R4: With `cfg_early`=1 the sync strobe is active in the first cycle after acceptance. The first data bit follows in the next cycle.
- R5: With `cfg_early`=0 the first data bit appears in the first cycle after acceptance. The sync strobe is active in the single cycle right after the last bit of the last word.
- R6: With `cfg_sync_inv`=0 the active sync level is 1. With `cfg_sync_inv`=1 it is 0. Outside its single-cycle pulse, the strobe rests at the inactive level of the last accepted sample.
- R7: `ser_data` is 0 in every cycle that carries no data bit. After reset, `ser_data` is 0 and `ser_sync` is 0.
- R8: A sample accepted while a frame is under way discards the old frame and restarts with the new words. In late-sync mode, a frame cut off before its last bit produces no sync strobe.
- R9: The configuration inputs and `in_words` matter only in the accept cycle. Changing them later leaves the frame being sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Always high; the block never stalls |
| in_words | input | 48 | Three 16-bit word slots, slot 0 in the low bits |
| cfg_nwords | input | 2 | Words per frame (0 acts as 1) |
| cfg_swap | input | 1 | Exchange the second and third slots in the send order |
| cfg_len_m1 | input | 4 | Bits per word minus one |
| cfg_early | input | 1 | 1: sync before the first bit; 0: sync after the last bit |
| cfg_sync_inv | input | 1 | 1: sync active low |
| ser_data | output | 1 | Serial data |
| ser_sync | output | 1 | Sync strobe |

## Verification
The bit and word counters, the frame state and the captured configuration all sit directly behind `ser_data` and `ser_sync`. A wrong count or a wrong word select therefore shows as a wrong serial bit in the very cycle it happens. A wrong end-of-word decision shows one bit early or late, and a wrong end-of-frame decision shifts the sync pulse by one or more cycles. A stale or unlatched configuration appears as soon as the bench changes the configuration inputs in the middle of a frame. Preemption faults show in the first cycle after a new sample arrives, because the bench compares every bit from that cycle against a fresh expected frame.

// File: rtl/sof_pkg.sv
package sof_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_POST = 2'd3
  } sof_state_e;
endpackage

// File: rtl/sof_order.sv
// Maps input slots to send positions; a swap exchanges the last two positions.
module sof_order #(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 3
) (
  input  logic [MAX_WORDS*WORD_W-1:0] words_in,
  input  logic                        swap,
  output logic [MAX_WORDS*WORD_W-1:0] words_out
);
  localparam int POS_A = MAX_WORDS - 2;
  localparam int POS_B = MAX_WORDS - 1;

  for (genvar s = 0; s < MAX_WORDS; s++) begin : g_slot
    if (s == POS_A) begin : g_a
      assign words_out[s*WORD_W +: WORD_W] =
        swap ? words_in[POS_B*WORD_W +: WORD_W] : words_in[s*WORD_W +: WORD_W];
    end else if (s == POS_B) begin : g_b
      assign words_out[s*WORD_W +: WORD_W] =
        swap ? words_in[POS_A*WORD_W +: WORD_W] : words_in[s*WORD_W +: WORD_W];
    end else begin : g_keep
      assign words_out[s*WORD_W +: WORD_W] = words_in[s*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/sof_counter.sv
// Bit-within-word and word-within-frame position counters.
module sof_counter #(
  parameter int LEN_W = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [LEN_W-1:0] len_m1,
  input  logic [CNT_W-1:0] nw_m1,
  output logic [LEN_W-1:0] bit_idx,
  output logic [CNT_W-1:0] word_idx,
  output logic             last
);
  logic word_end;

  assign word_end = (bit_idx == len_m1);
  assign last     = word_end && (word_idx == nw_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      word_idx <= '0;
    end else if (clear) begin
      bit_idx  <= '0;
      word_idx <= '0;
    end else if (step) begin
      if (word_end) begin
        bit_idx  <= '0;
        word_idx <= word_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sof_sync.sv
// Sync strobe level: active pulse XOR the captured inversion.
module sof_sync (
  input  logic active,
  input  logic inv,
  output logic sync_out
);
  assign sync_out = active ^ inv;
endmodule

// File: rtl/ser_out_fmt.sv
module ser_out_fmt #(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 3,
  parameter int LEN_W     = $clog2(WORD_W),
  parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [MAX_WORDS*WORD_W-1:0] in_words,
  input  logic [CNT_W-1:0]            cfg_nwords,
  input  logic                        cfg_swap,
  input  logic [LEN_W-1:0]            cfg_len_m1,
  input  logic                        cfg_early,
  input  logic                        cfg_sync_inv,
  output logic                        ser_data,
  output logic                        ser_sync
);
  import sof_pkg::*;

  localparam logic [LEN_W-1:0] MSB_POS  = LEN_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_WORDS);

  sof_state_e             st;
  logic [WORD_W-1:0]      words_q [MAX_WORDS];
  logic [MAX_WORDS*WORD_W-1:0] ordered;
  logic [CNT_W-1:0]       nw_eff;
  logic [CNT_W-1:0]       nw_m1_q;
  logic [LEN_W-1:0]       len_m1_q;
  logic                   early_q;
  logic                   inv_q;
  logic [LEN_W-1:0]       bit_idx;
  logic [CNT_W-1:0]       word_idx;
  logic                   frame_last;
  logic                   step;

  assign in_ready = 1'b1;

  sof_order #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_order (
    .words_in  (in_words),
    .swap      (cfg_swap),
    .words_out (ordered)
  );

  always_comb begin
    if (cfg_nwords == '0)          nw_eff = CNT_W'(1);
    else if (cfg_nwords > MAX_CNT) nw_eff = MAX_CNT;
    else                           nw_eff = cfg_nwords;
  end

  assign step = (st == ST_DATA) && !in_valid;

  sof_counter #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (in_valid),
    .step     (step),
    .len_m1   (len_m1_q),
    .nw_m1    (nw_m1_q),
    .bit_idx  (bit_idx),
    .word_idx (word_idx),
    .last     (frame_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nw_m1_q  <= '0;
      len_m1_q <= '0;
      early_q  <= 1'b0;
      inv_q    <= 1'b0;
    end else if (in_valid) begin
      nw_m1_q  <= nw_eff - 1'b1;
      len_m1_q <= cfg_len_m1;
      early_q  <= cfg_early;
      inv_q    <= cfg_sync_inv;
    end
  end

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        words_q[w] <= '0;
      else if (in_valid) words_q[w] <= ordered[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else if (in_valid) begin
      st <= cfg_early ? ST_PRE : ST_DATA;
    end else begin
      unique case (st)
        ST_PRE:  st <= ST_DATA;
        ST_DATA: if (frame_last) st <= early_q ? ST_IDLE : ST_POST;
        ST_POST: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ser_data = 1'b0;
    if (st == ST_DATA) ser_data = words_q[word_idx][MSB_POS - bit_idx];
  end

  sof_sync u_sync (
    .active   ((st == ST_PRE) || (st == ST_POST)),
    .inv      (inv_q),
    .sync_out (ser_sync)
  );
endmodule

// File: rtl/sof_chk.sv
module sof_chk (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                cfg_early,
  input logic                cfg_sync_inv,
  input logic                ser_data,
  input logic                ser_sync,
  input sof_pkg::sof_state_e st,
  input logic                inv_q
);
  import sof_pkg::*;

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R4
  early_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_early) |=> (ser_sync != $past(cfg_sync_inv)));

  // R5
  late_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_early) |=> (ser_sync == $past(cfg_sync_inv)));

  // R6
  one_bit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ser_sync != inv_q) && !in_valid) |=> (ser_sync == inv_q));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !ser_data);
endmodule

bind ser_out_fmt sof_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .cfg_early    (cfg_early),
  .cfg_sync_inv (cfg_sync_inv),
  .ser_data     (ser_data),
  .ser_sync     (ser_sync),
  .st           (st),
  .inv_q        (inv_q)
);

// File: tb/ser_out_fmt_bench.sv
module ser_out_fmt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_words = '0;
  logic [1:0]  cfg_nwords = '0;
  logic        cfg_swap = 1'b0;
  logic [3:0]  cfg_len_m1 = '0;
  logic        cfg_early = 1'b0;
  logic        cfg_sync_inv = 1'b0;
  logic        ser_data;
  logic        ser_sync;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  logic [15:0] e_w [3];
  int          e_n, e_len;
  bit          e_early, e_inv, e_swap;
  int          syncs_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_out_fmt u_ser_out_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_words(in_words), .cfg_nwords(cfg_nwords), .cfg_swap(cfg_swap),
    .cfg_len_m1(cfg_len_m1), .cfg_early(cfg_early), .cfg_sync_inv(cfg_sync_inv),
    .ser_data(ser_data), .ser_sync(ser_sync)
  );

  function automatic logic [15:0] slot_word(int k);
    if (e_swap && k == 1) return e_w[2];
    if (e_swap && k == 2) return e_w[1];
    return e_w[k];
  endfunction

  // Expected outputs t cycles after the accept edge.
  function automatic void expect_at(int t, output logic d, output logic s);
    int nb = e_n * e_len;
    int off = -1;
    logic [15:0] w;
    d = 1'b0;
    s = e_inv;
    if (e_early) begin
      if (t == 0) s = !e_inv;
      else if (t <= nb) off = t - 1;
    end else begin
      if (t < nb) off = t;
      else if (t == nb) s = !e_inv;
    end
    if (off >= 0) begin
      w = slot_word(off / e_len);
      d = w[15 - (off % e_len)];
    end
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(int t, string tag);
    logic d, s;
    expect_at(t, d, s);
    check(tag, "ser_data", ser_data, d);
    check(tag, "ser_sync", ser_sync, s);
    check("R1", "in_ready", in_ready, 1'b1);
    if (ser_sync != e_inv) syncs_seen++;
  endtask

  task automatic scramble();
    in_words     = {$urandom, $urandom};
    cfg_nwords   = 2'($urandom);
    cfg_swap     = 1'($urandom);
    cfg_len_m1   = 4'($urandom);
    cfg_early    = 1'($urandom);
    cfg_sync_inv = 1'($urandom);
  endtask

  // Called at a falling edge; cut < 0 checks the full frame plus idle cycles.
  task automatic frame(logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [1:0] n,
                       logic [3:0] lm1, bit early, bit inv, bit swap, int cut, string tag);
    int total;
    in_words = {c, b, a}; cfg_nwords = n; cfg_len_m1 = lm1;
    cfg_early = early; cfg_sync_inv = inv; cfg_swap = swap;
    in_valid = 1'b1;
    e_w[0] = a; e_w[1] = b; e_w[2] = c;
    e_n = (n == 0) ? 1 : int'(n); e_len = int'(lm1) + 1;
    e_early = early; e_inv = inv; e_swap = swap;
    @(negedge clk);
    in_valid = 1'b0;
    total = (cut < 0) ? e_n * e_len + 3 : cut;
    for (int t = 0; t < total; t++) begin
      compare(t, tag);
      scramble();  // R9: inputs wander after accept
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(SEED);
    syncs_seen = 0;
    check("R1", "in_ready in reset", in_ready, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7", "ser_data after reset", ser_data, 1'b0);
    check("R7", "ser_sync after reset", ser_sync, 1'b0);

    frame(16'hA5C3, 16'h1234, 16'hFFFF, 2'd3, 4'd15, 1'b1, 1'b0, 1'b0, -1, "R4");
    frame(16'h8001, 16'h7FFE, 16'h0F0F, 2'd3, 4'd15, 1'b0, 1'b0, 1'b0, -1, "R5");
    frame(16'hC001, 16'h4002, 16'h2003, 2'd2, 4'd7,  1'b1, 1'b1, 1'b0, -1, "R6");
    frame(16'hBEEF, 16'hDEAD, 16'h5555, 2'd3, 4'd3,  1'b0, 1'b1, 1'b1, -1, "R3");
    frame(16'h8000, 16'h0000, 16'hFFFF, 2'd0, 4'd0,  1'b0, 1'b0, 1'b0, -1, "R2");
    frame(16'hF00D, 16'h0001, 16'hAAAA, 2'd2, 4'd15, 1'b0, 1'b0, 1'b1, -1, "R3");
    // R8 preempt mid-frame, then new frame from scratch
    frame(16'hFFFF, 16'hFFFF, 16'hFFFF, 2'd3, 4'd15, 1'b1, 1'b0, 1'b0, 7, "R8");
    frame(16'h0000, 16'h9999, 16'h1111, 2'd2, 4'd11, 1'b0, 1'b0, 1'b0, -1, "R8");
    // R8 late mode: keep cutting before the final bit, no sync may appear
    syncs_seen = 0;
    for (int i = 0; i < 6; i++)
      frame(16'h1357, 16'h2468, 16'hFACE, 2'd2, 4'd5, 1'b0, 1'b1, 1'b0, 11, "R8");
    check("R8", "no sync under constant preemption", syncs_seen != 0, 1'b0);

    // R2/R9 random frames with random configuration
    for (int i = 0; i < 60; i++) begin
      int cut;
      cut = ($urandom % 4 == 0) ? int'($urandom % 20) + 1 : -1;
      frame(16'($urandom), 16'($urandom), 16'($urandom), 2'($urandom), 4'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), cut, "R2");
    end
    frame(16'h0F0F, 16'hF0F0, 16'h3C3C, 2'd3, 4'd15, 1'b1, 1'b0, 1'b1, -1, "R9");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule